// File: doc/BRIEF.md
# UART Buffer Status and Control Register

This block is the byte-wide status and control register that a host bus sees for the transmit and receive buffers of a UART. It samples the occupancy counts of both FIFOs and shows whether each is empty or full. It also mirrors the receive-line idle state and the software flow-control (XON) state. It holds one control bit that selects when the receiver raises its receive interrupt, and passes that bit on as a plain output.

Software flushes a buffer by writing a 1 into that buffer's empty bit. A 0 written there does nothing. A transmit flush also discards the byte held in the transmit shift register. Data bytes offered to the transmit FIFO pass through this block as a push strobe. When the FIFO is full the byte is dropped and a sticky write-error flag is raised. The flag stays set until software writes a 0 into it.

Top module: `uart_bufstat`

## Requirements
- R1: After reset the register reads 0x2E. Bit layout from bit 7 down to bit 0: write error, stop mode, TX empty, TX full, RX idle, XON, RX empty, RX full.
- R2: One cycle after a change of `tx_count`, TX empty (bit 5) reads 1 exactly when the count is 0, and TX full (bit 4) reads 1 exactly when the count equals TX_DEPTH.
- R3: One cycle after a change of `rx_count`, RX empty (bit 1) reads 1 exactly when the count is 0, and RX full (bit 0) reads 1 exactly when the count equals RX_DEPTH.
- R4: RX idle (bit 3) and XON (bit 2) show `rx_idle` and `xon_state` one cycle late. Register writes to bits 4, 3, 2 and 0 have no effect.
- R5: Bit 6 is a read/write control bit. It reads back the value last written, resets to 0, and drives `stop_mode`.
- R6: A `tx_wr` while `tx_count` is below TX_DEPTH gives `tx_push` = 1 in the same cycle. A `tx_wr` while `tx_count` equals TX_DEPTH gives `tx_push` = 0, and bit 7 reads 1 from the next cycle.
- R7: Bit 7 stays set until a register write carries 0 in bit 7. A register write carrying 1 in bit 7 leaves the bit unchanged.
- R8: If an overflowing `tx_wr` and a register write with bit 7 = 0 happen in the same cycle, bit 7 is left at 1.
- R9: A register write with bit 5 = 1 raises `tx_flush` and `tx_shift_flush` for exactly the next cycle. From that cycle TX empty reads 1 and TX full reads 0 for two cycles. After that the TX bits follow `tx_count` again.
- R10: A register write with bit 1 = 1 raises `rx_flush` for exactly the next cycle. From that cycle RX empty reads 1 and RX full reads 0 for two cycles. After that the RX bits follow `rx_count` again.
- R11: A register write with 0 in bit 5 or bit 1 produces no flush pulse and does not alter the empty bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tx_wr | input | 1 | Transmit data write strobe from the host |
| tx_push | output | 1 | Push strobe to the transmit FIFO (gated when full) |
| tx_count | input | $clog2(TX_DEPTH+1) | Transmit FIFO occupancy |
| rx_count | input | $clog2(RX_DEPTH+1) | Receive FIFO occupancy |
| rx_idle | input | 1 | Receive line idle indication |
| xon_state | input | 1 | Software flow-control transmit enable |
| tx_flush | output | 1 | One-cycle transmit FIFO flush pulse |
| tx_shift_flush | output | 1 | One-cycle transmit shift register discard pulse |
| rx_flush | output | 1 | One-cycle receive FIFO flush pulse |
| stop_mode | output | 1 | Receive interrupt timing select to the receiver |

## Verification
The hardest state to reach from the ports is an overflow event that lands in the same cycle as a software clear of the error flag. The bench holds `tx_count` at full depth and drives `tx_wr` and a register write of 0 in one cycle, then reads bit 7 back. The two-cycle forced-empty window after a flush is a second such case. It is reached by flushing while the occupancy input still shows a non-empty buffer, and the bench samples each of the following three cycles.

// File: rtl/ubs_pkg.sv
package ubs_pkg;

    // Field order is the software-visible bit layout, MSB first.
    typedef struct packed {
        logic wr_err;
        logic stop_sel;
        logic tx_empty;
        logic tx_full;
        logic rx_idle;
        logic xon;
        logic rx_empty;
        logic rx_full;
    } ubs_reg_t;

    localparam int BIT_ERR  = 7;
    localparam int BIT_STOP = 6;
    localparam int BIT_TXE  = 5;
    localparam int BIT_RXE  = 1;

    localparam ubs_reg_t UBS_RESET = '{wr_err: 1'b0, stop_sel: 1'b0, tx_empty: 1'b1,
                                       tx_full: 1'b0, rx_idle: 1'b1, xon: 1'b1,
                                       rx_empty: 1'b1, rx_full: 1'b0};

    function automatic logic wants_flush(input logic wr, input logic [7:0] d, input int pos);
        return wr && d[pos];
    endfunction

endpackage

// File: rtl/ubs_occ_status.sv
module ubs_occ_status #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush_req,
    input  logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          flush_pulse
);
    logic hold;

    // The pulse register doubles as the second cycle of the forced-empty window.
    assign hold = flush_req || flush_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_pulse <= 1'b0;
            empty       <= 1'b1;
            full        <= 1'b0;
        end else begin
            flush_pulse <= flush_req;
            empty       <= hold || (count == '0);
            full        <= !hold && (count == CW'(DEPTH));
        end
    end

    AST_FLUSH_FORCES_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |-> (empty && !full)); // R9
    AST_FLUSH_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> flush_pulse); // R10
    AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(empty && full)); // R2
    AST_ZERO_GIVES_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |=> empty); // R3

endmodule

// File: rtl/ubs_err_flag.sv
module ubs_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_req,
    output logic err
);
    always_ff @(posedge clk) begin
        if (rst)          err <= 1'b0;
        else if (set_evt) err <= 1'b1;   // a hardware event wins over a clear
        else if (clr_req) err <= 1'b0;
    end

    AST_ERR_SET_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> err); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err && !clr_req) |=> err); // R7

endmodule

// File: rtl/uart_bufstat.sv
module uart_bufstat #(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16,
    localparam int TXW = $clog2(TX_DEPTH + 1),
    localparam int RXW = $clog2(RX_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    input  logic           tx_wr,
    output logic           tx_push,
    input  logic [TXW-1:0] tx_count,
    input  logic [RXW-1:0] rx_count,
    input  logic           rx_idle,
    input  logic           xon_state,
    output logic           tx_flush,
    output logic           tx_shift_flush,
    output logic           rx_flush,
    output logic           stop_mode
);
    import ubs_pkg::*;

    ubs_reg_t view;
    logic     tx_full_now;
    logic     txe, txf, rxe, rxf, err;
    logic     stop_q, idle_q, xon_q;

    assign tx_full_now = (tx_count == TXW'(TX_DEPTH));
    assign tx_push     = tx_wr && !tx_full_now;

    ubs_occ_status #(.DEPTH(TX_DEPTH)) u_tx_occ (
        .clk(clk), .rst(rst),
        .flush_req(wants_flush(reg_wr, reg_wdata, BIT_TXE)),
        .count(tx_count), .empty(txe), .full(txf), .flush_pulse(tx_flush)
    );

    ubs_occ_status #(.DEPTH(RX_DEPTH)) u_rx_occ (
        .clk(clk), .rst(rst),
        .flush_req(wants_flush(reg_wr, reg_wdata, BIT_RXE)),
        .count(rx_count), .empty(rxe), .full(rxf), .flush_pulse(rx_flush)
    );

    assign tx_shift_flush = tx_flush;

    ubs_err_flag u_err (
        .clk(clk), .rst(rst),
        .set_evt(tx_wr && tx_full_now),
        .clr_req(reg_wr && !reg_wdata[BIT_ERR]),
        .err(err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= UBS_RESET.stop_sel;
            idle_q <= UBS_RESET.rx_idle;
            xon_q  <= UBS_RESET.xon;
        end else begin
            if (reg_wr) stop_q <= reg_wdata[BIT_STOP];
            idle_q <= rx_idle;
            xon_q  <= xon_state;
        end
    end

    always_comb begin
        view.wr_err   = err;
        view.stop_sel = stop_q;
        view.tx_empty = txe;
        view.tx_full  = txf;
        view.rx_idle  = idle_q;
        view.xon      = xon_q;
        view.rx_empty = rxe;
        view.rx_full  = rxf;
    end

    assign reg_rdata = view;
    assign stop_mode = stop_q;

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> (tx_count < TXW'(TX_DEPTH))); // R6
    AST_TX_PULSES_PAIRED: assert property (@(posedge clk) disable iff (rst)
        tx_flush |-> $past(reg_wr && reg_wdata[BIT_TXE])); // R9
    AST_STOP_WRITE: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (stop_mode == $past(reg_wdata[BIT_STOP]))); // R5
    AST_RX_FLUSH_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        rx_flush |-> $past(reg_wr && reg_wdata[BIT_RXE])); // R11

endmodule

// File: tb/uart_bufstat_bench.sv
module uart_bufstat_bench;
    localparam int TD = 4;
    localparam int RD = 4;
    localparam int TW = $clog2(TD + 1);
    localparam int RW = $clog2(RD + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          tx_wr = 1'b0;
    logic          tx_push;
    logic [TW-1:0] tx_count = '0;
    logic [RW-1:0] rx_count = '0;
    logic          rx_idle = 1'b1;
    logic          xon_state = 1'b1;
    logic          tx_flush, tx_shift_flush, rx_flush, stop_mode;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_bufstat #(.TX_DEPTH(TD), .RX_DEPTH(RD)) u_uart_bufstat (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_wr(tx_wr), .tx_push(tx_push),
        .tx_count(tx_count), .rx_count(rx_count), .rx_idle(rx_idle),
        .xon_state(xon_state), .tx_flush(tx_flush), .tx_shift_flush(tx_shift_flush),
        .rx_flush(rx_flush), .stop_mode(stop_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_view(input bit e, input bit s, input int t,
                                               input int r, input bit idl, input bit x);
        return {e, s, t == 0, t == TD, idl, x, r == 0, r == RD};
    endfunction

    task automatic reg_write(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit stp;
        stp = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset value", reg_rdata, 8'h2E);

        // R2 R3 R4 sweep of occupancy, idle and XON
        for (int t = 0; t <= TD; t++)
            for (int r = 0; r <= RD; r++)
                for (int k = 0; k < 4; k++) begin
                    tx_count = TW'(t); rx_count = RW'(r);
                    rx_idle = k[0]; xon_state = k[1];
                    @(negedge clk);
                    chk("R2 R3 R4 status sweep", reg_rdata,
                        expect_view(0, stp, t, r, k[0], k[1]));
                end

        // R4 R11 writes to read-only bits and zeros to empty bits
        tx_count = 2; rx_count = 3; rx_idle = 0; xon_state = 0;
        @(negedge clk);
        reg_write(8'h9D);
        chk("R4 R11 ignored bits", reg_rdata, expect_view(0, 0, 2, 3, 0, 0));
        chk("R11 no flush pulse", {5'b0, tx_flush, tx_shift_flush, rx_flush}, 8'h00);
        tx_count = 0; rx_count = 0;
        reg_write(8'h80);
        chk("R11 empty held on zero write", reg_rdata, expect_view(0, 0, 0, 0, 0, 0));

        // R5 stop mode
        reg_write(8'hC0); stp = 1;
        chk("R5 stop bit read", reg_rdata, expect_view(0, 1, 0, 0, 0, 0));
        chk("R5 stop output", {7'b0, stop_mode}, 8'h01);
        reg_write(8'h80); stp = 0;
        chk("R5 stop cleared", {7'b0, stop_mode}, 8'h00);

        // R6 push while not full, for every count below depth
        for (int t = 0; t < TD; t++) begin
            tx_count = TW'(t); tx_wr = 1; #1;
            chk("R6 push passes", {7'b0, tx_push}, 8'h01);
            @(negedge clk); tx_wr = 0;
            chk("R6 no error", {7'b0, reg_rdata[7]}, 8'h00);
        end
        tx_count = TW'(TD); tx_wr = 1; #1;
        chk("R6 push blocked when full", {7'b0, tx_push}, 8'h00);
        @(negedge clk); tx_wr = 0;
        chk("R6 error set", {7'b0, reg_rdata[7]}, 8'h01);

        // R7 sticky, writing 1 keeps it
        repeat (3) @(negedge clk);
        chk("R7 error sticky", {7'b0, reg_rdata[7]}, 8'h01);
        reg_write(8'h80);
        chk("R7 write one keeps", {7'b0, reg_rdata[7]}, 8'h01);
        reg_write(8'h00);
        chk("R7 write zero clears", {7'b0, reg_rdata[7]}, 8'h00);
        reg_write(8'h80);
        chk("R7 write one no set", {7'b0, reg_rdata[7]}, 8'h00);

        // R8 event and clear in one cycle
        tx_wr = 1; reg_wr = 1; reg_wdata = 8'h00;
        @(negedge clk);
        tx_wr = 0; reg_wr = 0;
        chk("R8 event wins", {7'b0, reg_rdata[7]}, 8'h01);
        reg_write(8'h00);
        chk("R8 cleared after", {7'b0, reg_rdata[7]}, 8'h00);

        // R9 transmit flush while full
        tx_count = TW'(TD); rx_count = 2;
        @(negedge clk);
        reg_write(8'hA0);
        chk("R9 pulses in cycle 1", {6'b0, tx_flush, tx_shift_flush}, 8'h03);
        chk("R9 empty cycle 1", reg_rdata[5:4], 2'b10);
        chk("R9 rx untouched", {7'b0, rx_flush}, 8'h00);
        @(negedge clk);
        chk("R9 pulses end", {6'b0, tx_flush, tx_shift_flush}, 8'h00);
        chk("R9 empty cycle 2", reg_rdata[5:4], 2'b10);
        @(negedge clk);
        chk("R9 follows count", reg_rdata[5:4], 2'b01);

        // R10 receive flush while partly filled
        reg_write(8'h82);
        chk("R10 pulse cycle 1", {6'b0, rx_flush, tx_flush}, 8'h02);
        chk("R10 empty cycle 1", reg_rdata[1:0], 2'b10);
        @(negedge clk);
        chk("R10 pulse ends", {7'b0, rx_flush}, 8'h00);
        chk("R10 empty cycle 2", reg_rdata[1:0], 2'b10);
        @(negedge clk);
        chk("R10 follows count", reg_rdata[1:0], 2'b00);
        rx_count = RW'(RD);
        @(negedge clk);
        chk("R10 full again", reg_rdata[1:0], 2'b01);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule